// File: doc/BRIEF.md
# Write-Blocked Compare Timer

This block is an up-counter with one or two compare channels, meant for a small controller-style peripheral. It is fully synchronous to one system clock. The counter moves forward only on cycles where the `tick` enable is high. That enable comes from a prescaler outside the block, or it is tied high for full-rate counting. Each channel holds a compare value. When the counter equals that value on a tick, the channel sets its flag. When the counter rolls over from its all-ones value to zero, the block sets an overflow flag. Each flag drives an interrupt output through its own enable bit.

Software reaches the block through a byte-wide register bus. Reads are combinational on the address. Writes take effect at the clock edge.

In 16-bit mode the counter is loaded in two steps:
- A high-byte write goes to a holding register and does not touch the counter.
- A low-byte write then loads both bytes at once. This load is called a commit.

After every commit, a two-state block machine suppresses all compare matches on the next tick. This lets software load the counter with a value equal to a compare register without raising that channel's flag. The machine has two states:
- BLK_OPEN: matches are allowed.
- BLK_SHUT: matches are suppressed.

Its transitions are:
- ARM: a commit in BLK_OPEN moves to BLK_SHUT.
- HOLD: while in BLK_SHUT, a new commit, or a cycle with no tick, keeps BLK_SHUT.
- RELEASE: a tick cycle without a commit moves back to BLK_OPEN.

Top module: `wbc_timer`

## Requirements
- R1: A synchronous reset clears the counter, the high-byte holding register, both compare registers, the flags and the interrupt enables. It also returns the block machine to BLK_OPEN.
- R2: The counter increments by one at each clock edge where `tick` is high and no commit occurs. With `tick` low and no commit, it holds its value.
- R3: On a tick at which the counter holds all ones (MAX), the counter wraps to zero and sets flag bit 0 (overflow). Register address 6 reads the flags.
- R4: In 16-bit mode, a write to address 1 only loads the holding register, and the counter keeps its value. A write to address 0 commits {holding register, written byte} into the counter. Reads of address 0 and address 1 return the counter's low and high bytes.
- R5: A commit wins over a tick in the same cycle: the counter takes the written value, and that cycle gives no increment, no overflow and no compare match.
- R6: Channel c has its compare value at addresses 2+2c (low byte) and 3+2c (high byte). A tick in BLK_OPEN with the counter equal to that value sets flag bit 1+c.
- R7: After a commit, no compare flag is set on the first following tick cycle, however many idle cycles come before it. Matches on later ticks set flags normally.
- R8: Flags stay set until cleared. Writing a one to a bit of address 6 clears that flag, and writing a zero to a bit leaves it unchanged.
- R9: When a flag's set event and a write-one clear of that flag fall in the same cycle, the flag ends up set.
- R10: Address 7 holds the interrupt enables, with the same bit positions as the flags. `ovf_irq` equals flag 0 AND enable 0. `cmp_irq[c]` equals flag 1+c AND enable 1+c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer-tick enable from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cmp_irq | output | NCH | Per-channel compare interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Different internal faults show up at the ports at different times:
- Block machine stuck in BLK_SHUT: every later match is lost. This shows as a flag at address 6 that never sets, one tick after the counter reaches the compare value.
- Block machine never leaving BLK_OPEN: a commit equal to a compare value raises the flag on the very next tick.
- Holding register faults: these are visible right after the low-byte write, as a wrong high byte at address 1.
- Counter that ignores the tick gating: this is seen on the first idle cycle.

The bench samples each of these at the first cycle in which the fault could appear.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    localparam int WBC_AW = 3;
    localparam int WBC_DW = 8;

    localparam logic [WBC_AW-1:0] WBC_A_CNT_LO = 3'd0;
    localparam logic [WBC_AW-1:0] WBC_A_CNT_HI = 3'd1;
    localparam logic [WBC_AW-1:0] WBC_A_CMP0   = 3'd2;
    localparam logic [WBC_AW-1:0] WBC_A_FLAGS  = 3'd6;
    localparam logic [WBC_AW-1:0] WBC_A_IEN    = 3'd7;

    typedef enum logic {
        BLK_OPEN = 1'b0,
        BLK_SHUT = 1'b1
    } blk_state_t;
endpackage

// File: rtl/wbc_blocker.sv
module wbc_blocker
    import wbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic tick,
    output logic match_ok,
    output logic blocked
);
    blk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= BLK_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_OPEN: if (commit) state_d = BLK_SHUT;          // ARM
            BLK_SHUT: begin
                if (commit)    state_d = BLK_SHUT;             // HOLD
                else if (tick) state_d = BLK_OPEN;             // RELEASE
            end
            default:  state_d = BLK_OPEN;
        endcase
    end

    always_comb begin
        blocked  = (state_q == BLK_SHUT);
        match_ok = tick && !commit && (state_q == BLK_OPEN);
    end
endmodule

// File: rtl/wbc_counter.sv
module wbc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= cnt + 1'b1;
    end

    assign wrap = tick && !load && (cnt == MAXV);
endmodule

// File: rtl/wbc_cmp_chan.sv
module wbc_cmp_chan
    import wbc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WBC_DW-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              match_ok,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              hit
);
    logic [7:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst)        lo_q <= '0;
        else if (wr_lo) lo_q <= wdata;
    end

    generate
        if (CNT_W > 8) begin : g_wide
            logic [CNT_W-9:0] hi_q;
            always_ff @(posedge clk) begin
                if (rst)        hi_q <= '0;
                else if (wr_hi) hi_q <= wdata[CNT_W-9:0];
            end
            assign cmp_val = {hi_q, lo_q};
        end else begin : g_narrow
            logic unused_hi;
            assign unused_hi = wr_hi;
            assign cmp_val   = lo_q;
        end
    endgenerate

    assign hit = match_ok && (cnt == cmp_val);
endmodule

// File: rtl/wbc_timer.sv
module wbc_timer
    import wbc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [WBC_AW-1:0] bus_addr,
    input  logic [WBC_DW-1:0] bus_wdata,
    output logic [WBC_DW-1:0] bus_rdata,
    output logic [NCH-1:0]    cmp_irq,
    output logic              ovf_irq
);
    localparam int NFLG = NCH + 1;

    logic             cnt_commit;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             match_ok;
    logic             blocked;
    logic [7:0]       tmp_hi_q;
    logic [NCH-1:0]   hit;
    logic [NFLG-1:0]  flags_q, ien_q, set_vec, clr_vec;
    logic [15:0]      cnt_ext;
    logic [15:0]      cmp_ext [NCH];

    assign cnt_commit = bus_wr && (bus_addr == WBC_A_CNT_LO);
    assign load_val   = CNT_W'({tmp_hi_q, bus_wdata});

    always_ff @(posedge clk) begin
        if (rst)
            tmp_hi_q <= '0;
        else if (bus_wr && (bus_addr == WBC_A_CNT_HI) && (CNT_W > 8))
            tmp_hi_q <= bus_wdata;
    end

    wbc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(cnt_commit),
        .load_val(load_val), .cnt(cnt_q), .wrap(wrap)
    );

    wbc_blocker u_blk (
        .clk(clk), .rst(rst), .commit(cnt_commit), .tick(tick),
        .match_ok(match_ok), .blocked(blocked)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            localparam logic [WBC_AW-1:0] LO_ADDR = WBC_AW'(WBC_A_CMP0 + 2*ch);
            localparam logic [WBC_AW-1:0] HI_ADDR = WBC_AW'(WBC_A_CMP0 + 2*ch + 1);
            logic [CNT_W-1:0] cmp_val;
            wbc_cmp_chan #(.CNT_W(CNT_W)) u_chan (
                .clk(clk), .rst(rst),
                .wr_lo(bus_wr && (bus_addr == LO_ADDR)),
                .wr_hi(bus_wr && (bus_addr == HI_ADDR)),
                .wdata(bus_wdata), .cnt(cnt_q), .match_ok(match_ok),
                .cmp_val(cmp_val), .hit(hit[ch])
            );
            assign cmp_ext[ch] = 16'(cmp_val);
        end
    endgenerate

    assign set_vec = {hit, wrap};
    assign clr_vec = (bus_wr && (bus_addr == WBC_A_FLAGS)) ? bus_wdata[NFLG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ien_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (bus_wr && (bus_addr == WBC_A_IEN))
                ien_q <= bus_wdata[NFLG-1:0];
        end
    end

    assign ovf_irq = flags_q[0] & ien_q[0];
    assign cmp_irq = flags_q[NFLG-1:1] & ien_q[NFLG-1:1];

    assign cnt_ext = 16'(cnt_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            WBC_A_CNT_LO: bus_rdata = cnt_ext[7:0];
            WBC_A_CNT_HI: bus_rdata = cnt_ext[15:8];
            WBC_A_FLAGS:  bus_rdata = WBC_DW'(flags_q);
            WBC_A_IEN:    bus_rdata = WBC_DW'(ien_q);
            default: begin
                for (int c = 0; c < NCH; c++) begin
                    if (bus_addr == WBC_AW'(WBC_A_CMP0 + 2*c))
                        bus_rdata = cmp_ext[c][7:0];
                    if (bus_addr == WBC_AW'(WBC_A_CMP0 + 2*c + 1))
                        bus_rdata = cmp_ext[c][15:8];
                end
            end
        endcase
    end
endmodule

// File: rtl/wbc_timer_chk.sv
module wbc_timer_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             commit,
    input logic             blocked,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_val,
    input logic [NCH:0]     flags,
    input logic [NCH:0]     set_vec,
    input logic [NCH:0]     clr_vec
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && flags == '0 && !blocked));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !commit) |=> $stable(cnt));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !commit) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !commit && (&cnt)) |=> flags[0]);

    // R5
    commit_load_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt == $past(load_val)));

    // R7
    blk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (blocked && !commit) |=> ((flags[NCH:1] & ~$past(flags[NCH:1])) == '0));

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (|flags) |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec)));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & clr_vec)) |=> ((flags & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

bind wbc_timer wbc_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) chk_i (
    .clk(clk), .rst(rst), .tick(tick), .commit(cnt_commit), .blocked(blocked),
    .cnt(cnt_q), .load_val(load_val), .flags(flags_q),
    .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/wbc_timer_tb_top.sv
module wbc_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cmp_irq;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbc_timer #(.CNT_W(16), .NCH(2)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] v);
        wr(3'd1, v[15:8]);
        wr(3'd0, v[7:0]);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'd0, lo);
        rd(3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 register clear after reset", d, 8'h00);
        end
        chk("R1 irqs low after reset", {cmp_irq, ovf_irq}, 3'b000);
    endtask

    task automatic t_hold_reg();
        logic [15:0] v;
        wr(3'd1, 8'h12);
        rd16(v);
        chk("R4 high byte write leaves counter", v, 16'h0000);
        wr(3'd0, 8'h34);
        rd16(v);
        chk("R4 low byte commits both", v, 16'h1234);
    endtask

    task automatic t_count();
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rd16(v);
        chk("R2 idle holds", v, 16'h1234);
        run_ticks(5);
        rd16(v);
        chk("R2 five ticks", v, 16'h1239);
        repeat (2) @(negedge clk);
        rd16(v);
        chk("R2 idle after ticks", v, 16'h1239);
        for (int i = 0; i < 4; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
        rd16(v);
        chk("R2 prescaled ticks", v, 16'h123D);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        logic [7:0]  d;
        wr16(16'hFFFE);
        run_ticks(1);
        rd16(v);
        chk("R3 reaches MAX", v, 16'hFFFF);
        rd(3'd6, d);
        chk("R3 no overflow at MAX", d, 8'h00);
        run_ticks(1);
        rd16(v);
        chk("R3 wraps to zero", v, 16'h0000);
        rd(3'd6, d);
        chk("R3 overflow flag", d, 8'h01);
        chk("R10 ovf irq masked", ovf_irq, 1'b0);
        wr(3'd7, 8'h01);
        chk("R10 ovf irq enabled", ovf_irq, 1'b1);
        wr(3'd6, 8'h00);
        rd(3'd6, d);
        chk("R8 zero write keeps flag", d, 8'h01);
        wr(3'd6, 8'h01);
        rd(3'd6, d);
        chk("R8 write one clears", d, 8'h00);
        chk("R10 ovf irq drops", ovf_irq, 1'b0);
        wr(3'd7, 8'h00);
    endtask

    task automatic t_commit_tick();
        logic [15:0] v;
        logic [7:0]  d;
        wr16(16'hFFFF);
        wr(3'd1, 8'h00);
        wr_tick(3'd0, 8'h00);
        rd16(v);
        chk("R5 commit beats tick", v, 16'h0000);
        rd(3'd6, d);
        chk("R5 no overflow on commit", d, 8'h00);
        wr_tick(3'd0, 8'h50);
        rd16(v);
        chk("R5 commit no increment", v, 16'h0050);
    endtask

    task automatic t_match();
        logic [15:0] v;
        logic [7:0]  d;
        wr(3'd2, 8'h10);
        wr(3'd3, 8'h00);
        rd(3'd2, d);
        chk("R6 compare low readback", d, 8'h10);
        wr16(16'h000E);
        run_ticks(2);
        rd(3'd6, d);
        chk("R6 no flag before match tick", d, 8'h00);
        run_ticks(1);
        rd16(v);
        chk("R6 counter past match", v, 16'h0011);
        rd(3'd6, d);
        chk("R6 channel 0 flag", d, 8'h02);
        wr(3'd7, 8'h02);
        chk("R10 cmp irq channel 0", cmp_irq, 2'b01);
        wr(3'd6, 8'h02);
        rd(3'd6, d);
        chk("R8 cmp flag cleared", d, 8'h00);
        chk("R10 cmp irq drops", cmp_irq, 2'b00);
        wr(3'd7, 8'h00);
    endtask

    task automatic t_block();
        logic [15:0] v;
        logic [7:0]  d;
        wr16(16'h0010);
        run_ticks(1);
        rd16(v);
        chk("R7 counter moved", v, 16'h0011);
        rd(3'd6, d);
        chk("R7 equal write blocks match", d, 8'h00);
        wr16(16'h0010);
        repeat (4) @(negedge clk);
        run_ticks(1);
        rd(3'd6, d);
        chk("R7 block spans idle cycles", d, 8'h00);
        wr(3'd4, 8'h12);
        wr(3'd5, 8'h00);
        run_ticks(1);
        rd(3'd6, d);
        chk("R7 no flag at 0x11", d, 8'h00);
        run_ticks(1);
        rd(3'd6, d);
        chk("R7 later match channel 1", d, 8'h04);
        wr(3'd6, 8'h04);
        wr16(16'h000F);
        run_ticks(2);
        rd(3'd6, d);
        chk("R7 second tick matches", d, 8'h02);
        wr(3'd6, 8'h02);
    endtask

    task automatic t_prio();
        logic [7:0] d;
        wr16(16'h000F);
        run_ticks(1);
        rd(3'd6, d);
        chk("R9 setup no flag", d, 8'h00);
        wr_tick(3'd6, 8'h02);
        rd(3'd6, d);
        chk("R9 set wins over clear", d, 8'h02);
        wr(3'd6, 8'h02);
        rd(3'd6, d);
        chk("R9 later clear works", d, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hold_reg();
        t_count();
        t_wrap();
        t_commit_tick();
        t_match();
        t_block();
        t_prio();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule